// File: doc/BRIEF.md
# LCD Panel Frame Timing Generator

This block drives the timing of a single display panel. From five packed configuration words it produces horizontal sync, vertical sync, a display-enable qualifier, and single-cycle frame-start and frame-end events. One clock cycle is one dot. All horizontal quantities are programmed in groups of 8 dots. All vertical quantities are programmed in whole lines.

There are two ways to run it. In refresh mode, frames follow one another with no gap. In single-frame mode the generator waits idle, with every output at its inactive level. Each trigger pulse then produces exactly one frame, which is followed by a frame-end event. A trigger that arrives while a frame is in progress is held, and it produces one more frame right after the current one.

Configuration words are sampled into a shadow copy only at the start of a frame. Software can therefore rewrite them at any time without tearing the frame in progress.

Top module: `lcd_frame_timer`

## Requirements
- R1: While reset is held and in the first cycle after it, hsync_o, vsync_o, den_o, frame_start_o and frame_end_o are all 0.
- R2: A line lasts hcount_cfg[15:0]×8 cycles. den_o is active for the first hcount_cfg[31:16]×8 dots of each active line.
- R3: hsync_o is active from dot hsync_cfg[15:0]×8 for hsync_cfg[31:16]×8 dots of every line, counting dots from 0.
- R4: A frame has vcount_cfg[15:0] lines. den_o is active only in lines numbered below vcount_cfg[31:16], counting lines from 0.
- R5: vsync_o is active for whole lines, from line vsync_cfg[15:0] for vsync_cfg[31:16] lines.
- R6: mode_cfg bit 28 makes vsync_o active low, bit 27 makes hsync_o active low, and bit 24 makes den_o active low. When idle, each output sits at its inactive level.
- R7: frame_start_o is high for exactly one cycle, at dot 0 of line 0 of every frame.
- R8: frame_end_o is high for one cycle, in the cycle after the last dot of the last line.
- R9: With oneshot_sel=0, the next frame starts in the cycle right after the last dot, so frame_start_o coincides with frame_end_o.
- R10: With oneshot_sel=1 and no trigger, no frame starts. A trigger pulse starts exactly one frame in the next cycle, and the generator then returns to idle.
- R11: In single-frame mode, a trigger that arrives during a frame produces exactly one further frame, which begins right after the current one.
- R12: Configuration changes made during a frame take effect only at the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hcount_cfg | input | 32 | [15:0] total line width /8, [31:16] active width /8 |
| hsync_cfg | input | 32 | [15:0] sync start /8, [31:16] sync width /8 |
| vcount_cfg | input | 32 | [15:0] total lines, [31:16] active lines |
| vsync_cfg | input | 32 | [15:0] sync start line, [31:16] sync length in lines |
| mode_cfg | input | 32 | Polarity bits 28 (vsync), 27 (hsync), 24 (enable) |
| oneshot_sel | input | 1 | 1 selects single-frame mode, 0 selects continuous refresh |
| trigger | input | 1 | One-cycle request for a frame in single-frame mode |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| den_o | output | 1 | Display enable |
| frame_start_o | output | 1 | First dot of a frame |
| frame_end_o | output | 1 | Cycle after the last dot of a frame |

## Verification
Two geometries are used: a 32-dot by 5-line frame and a 24-dot by 4-line frame. They have different sync offsets and widths, so an error in dot-group scaling, in a window edge or in field packing moves an edge that the per-cycle model checks. Single-frame runs use an isolated trigger, then a second trigger placed mid-frame, which separates correct trigger queuing from dropped or doubled frames. Continuous runs show whether there is a gap cycle at the wrap. A mid-frame configuration rewrite tells shadowed sampling apart from live use by measuring the length of the current frame and then of the next one. Inverted-polarity runs check the active and idle levels of each output.

// File: rtl/lcdtg_pkg.sv
package lcdtg_pkg;
  localparam int REG_W     = 32;
  localparam int FLD_W     = 16;
  localparam int HI_LSB    = 16;
  localparam int POL_V_BIT = 28;
  localparam int POL_H_BIT = 27;
  localparam int POL_E_BIT = 24;

  typedef struct packed {
    logic [FLD_W-1:0] h_tot;
    logic [FLD_W-1:0] h_act;
    logic [FLD_W-1:0] h_sp;
    logic [FLD_W-1:0] h_sw;
    logic [FLD_W-1:0] v_tot;
    logic [FLD_W-1:0] v_act;
    logic [FLD_W-1:0] v_sp;
    logic [FLD_W-1:0] v_sw;
    logic             pol_v;
    logic             pol_h;
    logic             pol_e;
  } tcfg_t;

  function automatic logic [FLD_W-1:0] lo_field(input logic [REG_W-1:0] w);
    return w[FLD_W-1:0];
  endfunction

  function automatic logic [FLD_W-1:0] hi_field(input logic [REG_W-1:0] w);
    return w[HI_LSB +: FLD_W];
  endfunction

  // group count to dot count
  function automatic logic [31:0] to_dots(input logic [FLD_W-1:0] g, input int sh);
    return 32'(g) << sh;
  endfunction

  // half-open window [start, start+width)
  function automatic logic in_window(input logic [31:0] p, input logic [31:0] s,
                                     input logic [31:0] w);
    return (p >= s) && (p < s + w);
  endfunction

  function automatic tcfg_t unpack_cfg(input logic [REG_W-1:0] hc, input logic [REG_W-1:0] hs,
                                       input logic [REG_W-1:0] vc, input logic [REG_W-1:0] vs,
                                       input logic [REG_W-1:0] md);
    tcfg_t c;
    c.h_tot = lo_field(hc);
    c.h_act = hi_field(hc);
    c.h_sp  = lo_field(hs);
    c.h_sw  = hi_field(hs);
    c.v_tot = lo_field(vc);
    c.v_act = hi_field(vc);
    c.v_sp  = lo_field(vs);
    c.v_sw  = hi_field(vs);
    c.pol_v = md[POL_V_BIT];
    c.pol_h = md[POL_H_BIT];
    c.pol_e = md[POL_E_BIT];
    return c;
  endfunction
endpackage

// File: rtl/lcdtg_shadow.sv
module lcdtg_shadow
  import lcdtg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  tcfg_t cfg_in,
  output tcfg_t cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (load) cfg_q <= cfg_in;
  end
endmodule

// File: rtl/lcdtg_seq.sv
module lcdtg_seq
  import lcdtg_pkg::*;
#(
  parameter int DOT_SHIFT = 3,
  localparam int HCW = FLD_W + DOT_SHIFT
)(
  input  logic             clk,
  input  logic             rst_n,
  input  tcfg_t            cfg,
  input  logic             oneshot,
  input  logic             trig,
  output logic             run,
  output logic [HCW-1:0]   hpos,
  output logic [FLD_W-1:0] vpos,
  output logic             load,
  output logic             frame_start,
  output logic             frame_end
);
  localparam logic [HCW-1:0]   H_ONE = 1;
  localparam logic [FLD_W-1:0] V_ONE = 1;

  logic pending;
  logic go;
  logic line_last;
  logic frame_last;

  assign go         = !oneshot || pending || trig;
  assign line_last  = (32'(hpos) == to_dots(cfg.h_tot, DOT_SHIFT) - 32'd1);
  assign frame_last = line_last && (32'(vpos) == 32'(cfg.v_tot) - 32'd1);
  assign load       = run ? (frame_last && go) : go;
  assign frame_start = run && (hpos == '0) && (vpos == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run       <= 1'b0;
      hpos      <= '0;
      vpos      <= '0;
      pending   <= 1'b0;
      frame_end <= 1'b0;
    end else begin
      frame_end <= run && frame_last;
      pending   <= load ? 1'b0 : (pending | trig);
      if (!run) begin
        if (go) begin
          run  <= 1'b1;
          hpos <= '0;
          vpos <= '0;
        end
      end else if (frame_last) begin
        hpos <= '0;
        vpos <= '0;
        run  <= go;
      end else if (line_last) begin
        hpos <= '0;
        vpos <= vpos + V_ONE;
      end else begin
        hpos <= hpos + H_ONE;
      end
    end
  end

  // R7
  fs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
  // R8
  fe_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> frame_end);
  // R2
  hpos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (32'(hpos) < to_dots(cfg.h_tot, DOT_SHIFT)));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && oneshot && !pending && !trig) |=> !run);
  // R9
  cont_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && frame_last && !oneshot) |=> (run && frame_start && frame_end));
endmodule

// File: rtl/lcdtg_out.sv
module lcdtg_out
  import lcdtg_pkg::*;
#(
  parameter int DOT_SHIFT = 3,
  localparam int HCW = FLD_W + DOT_SHIFT
)(
  input  tcfg_t            cfg,
  input  logic             run,
  input  logic [HCW-1:0]   hpos,
  input  logic [FLD_W-1:0] vpos,
  output logic             hsync,
  output logic             vsync,
  output logic             den
);
  logic hs_raw, vs_raw, de_raw;

  always_comb begin
    hs_raw = run && in_window(32'(hpos), to_dots(cfg.h_sp, DOT_SHIFT),
                              to_dots(cfg.h_sw, DOT_SHIFT));
    vs_raw = run && in_window(32'(vpos), 32'(cfg.v_sp), 32'(cfg.v_sw));
    de_raw = run && (32'(hpos) < to_dots(cfg.h_act, DOT_SHIFT))
                 && (vpos < cfg.v_act);
    hsync  = hs_raw ^ cfg.pol_h;
    vsync  = vs_raw ^ cfg.pol_v;
    den    = de_raw ^ cfg.pol_e;
  end
endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
  import lcdtg_pkg::*;
#(
  parameter int DOT_SHIFT = 3,
  localparam int HCW = FLD_W + DOT_SHIFT
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] hcount_cfg,
  input  logic [31:0] hsync_cfg,
  input  logic [31:0] vcount_cfg,
  input  logic [31:0] vsync_cfg,
  input  logic [31:0] mode_cfg,
  input  logic        oneshot_sel,
  input  logic        trigger,
  output logic        hsync_o,
  output logic        vsync_o,
  output logic        den_o,
  output logic        frame_start_o,
  output logic        frame_end_o
);
  tcfg_t            cfg_live;
  tcfg_t            cfg_q;
  logic             run;
  logic             load;
  logic [HCW-1:0]   hpos;
  logic [FLD_W-1:0] vpos;

  assign cfg_live = unpack_cfg(hcount_cfg, hsync_cfg, vcount_cfg, vsync_cfg, mode_cfg);

  lcdtg_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .load(load), .cfg_in(cfg_live), .cfg_q(cfg_q)
  );

  lcdtg_seq #(.DOT_SHIFT(DOT_SHIFT)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .oneshot(oneshot_sel), .trig(trigger),
    .run(run), .hpos(hpos), .vpos(vpos), .load(load),
    .frame_start(frame_start_o), .frame_end(frame_end_o)
  );

  lcdtg_out #(.DOT_SHIFT(DOT_SHIFT)) u_out (
    .cfg(cfg_q), .run(run), .hpos(hpos), .vpos(vpos),
    .hsync(hsync_o), .vsync(vsync_o), .den(den_o)
  );

  // R12
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !frame_start_o) |-> $stable(cfg_q));
endmodule

// File: tb/tb_lcd_frame_timer.sv
module tb_lcd_frame_timer;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [31:0] hc, hs, vc, vs, md;
  logic        os, trig;
  logic        hs_o, vs_o, de_o, fs_o, fe_o;

  lcd_frame_timer dut (
    .clk(clk), .rst_n(rst_n), .hcount_cfg(hc), .hsync_cfg(hs), .vcount_cfg(vc),
    .vsync_cfg(vs), .mode_cfg(md), .oneshot_sel(os), .trigger(trig),
    .hsync_o(hs_o), .vsync_o(vs_o), .den_o(de_o), .frame_start_o(fs_o), .frame_end_o(fe_o)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  int fs_cnt = 0, fe_cnt = 0, fe_nofs = 0;

  // behavioural model: a linear dot index within the frame
  bit m_run, m_pend, m_fe;
  int m_pos;
  int s_ht, s_ha, s_hsp, s_hsw, s_vt, s_va, s_vsp, s_vsw;
  bit s_pv, s_ph, s_pe;

  function automatic void chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endfunction

  task automatic grab();
    s_ht = hc[15:0]; s_ha = hc[31:16]; s_hsp = hs[15:0]; s_hsw = hs[31:16];
    s_vt = vc[15:0]; s_va = vc[31:16]; s_vsp = vs[15:0]; s_vsw = vs[31:16];
    s_pv = md[28]; s_ph = md[27]; s_pe = md[24];
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_pend = 0; m_fe = 0; m_pos = 0;
      s_ht = 0; s_ha = 0; s_hsp = 0; s_hsw = 0; s_vt = 0; s_va = 0; s_vsp = 0; s_vsw = 0;
      s_pv = 0; s_ph = 0; s_pe = 0;
    end else begin
      bit want;
      want = !os || m_pend || trig;
      if (!m_run) begin
        m_fe = 0;
        if (want) begin grab(); m_run = 1; m_pos = 0; m_pend = 0; end
      end else if (m_pos == s_ht * 8 * s_vt - 1) begin
        m_fe = 1;
        if (want) begin grab(); m_pos = 0; m_pend = 0; end
        else m_run = 0;
      end else begin
        m_fe = 0;
        m_pos++;
        if (trig) m_pend = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int len, hh, vv;
      bit ehs, evs, ede, efs;
      len = s_ht * 8;
      hh = (m_run && len > 0) ? m_pos % len : 0;
      vv = (m_run && len > 0) ? m_pos / len : 0;
      ehs = m_run && hh >= s_hsp * 8 && hh < (s_hsp + s_hsw) * 8;
      evs = m_run && vv >= s_vsp && vv < s_vsp + s_vsw;
      ede = m_run && hh < s_ha * 8 && vv < s_va;
      efs = m_run && m_pos == 0;
      chk(hs_o == (ehs ^ s_ph), "R3 hsync", int'(hs_o), int'(ehs ^ s_ph));
      chk(vs_o == (evs ^ s_pv), "R5 vsync", int'(vs_o), int'(evs ^ s_pv));
      chk(de_o == (ede ^ s_pe), "R2/R4 den", int'(de_o), int'(ede ^ s_pe));
      chk(fs_o == efs, "R7 frame_start", int'(fs_o), int'(efs));
      chk(fe_o == m_fe, "R8 frame_end", int'(fe_o), int'(m_fe));
      if (fs_o) fs_cnt++;
      if (fe_o) fe_cnt++;
      if (fe_o && !fs_o && !os) fe_nofs++;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      checks++; fails++;
      $display("FAIL R10 watchdog expired actual=%0d expected<%0d", cyc, 100000);
      finish_run();
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic pulse_trig();
    trig = 1; tick(); trig = 0;
  endtask

  task automatic cfg_a();
    hc = {16'd2, 16'd4}; hs = {16'd1, 16'd2}; vc = {16'd3, 16'd5}; vs = {16'd1, 16'd3};
  endtask

  task automatic cfg_b();
    hc = {16'd1, 16'd3}; hs = {16'd1, 16'd1}; vc = {16'd2, 16'd4}; vs = {16'd2, 16'd2};
  endtask

  task automatic clr_counts();
    fs_cnt = 0; fe_cnt = 0; fe_nofs = 0;
  endtask

  initial begin
    int n;
    rst_n = 0; os = 1; trig = 0; md = 0;
    cfg_a();
    repeat (3) tick();
    // R1 reset state
    chk(hs_o == 0, "R1 hsync in reset", int'(hs_o), 0);
    chk(vs_o == 0, "R1 vsync in reset", int'(vs_o), 0);
    chk(de_o == 0, "R1 den in reset", int'(de_o), 0);
    chk(fs_o == 0 && fe_o == 0, "R1 events in reset", int'({fs_o, fe_o}), 0);
    rst_n = 1;
    tick();
    chk(!hs_o && !vs_o && !de_o && !fs_o && !fe_o, "R1 after release",
        int'({hs_o, vs_o, de_o, fs_o, fe_o}), 0);
    // R10 idle without trigger
    repeat (20) tick();
    chk(fs_cnt == 0, "R10 no frame without trigger", fs_cnt, 0);
    // R10 single trigger gives exactly one frame
    clr_counts();
    pulse_trig();
    repeat (400) tick();
    chk(fs_cnt == 1, "R10 one frame per trigger", fs_cnt, 1);
    chk(fe_cnt == 1, "R10 one frame end per trigger", fe_cnt, 1);
    // R11 trigger during a frame queues one more
    clr_counts();
    pulse_trig();
    repeat (50) tick();
    pulse_trig();
    repeat (500) tick();
    chk(fs_cnt == 2, "R11 queued trigger frames", fs_cnt, 2);
    chk(fe_cnt == 2, "R11 queued trigger frame ends", fe_cnt, 2);
    // R6 inverted polarity, then idle levels
    md = 32'h1900_0000;
    pulse_trig();
    repeat (200) tick();
    chk(hs_o == 1, "R6 hsync idle level inverted", int'(hs_o), 1);
    chk(vs_o == 1, "R6 vsync idle level inverted", int'(vs_o), 1);
    chk(de_o == 1, "R6 den idle level inverted", int'(de_o), 1);
    md = 0;
    // R9 continuous refresh with no gap
    os = 0;
    clr_counts();
    repeat (500) tick();
    chk(fe_nofs == 0, "R9 frame end without next start", fe_nofs, 0);
    chk(fs_cnt >= 3, "R9 frames in continuous run", fs_cnt, 3);
    // R12 mid-frame config change applies at next frame
    n = 0;
    while (!fs_o) tick();
    repeat (10) begin tick(); n++; end
    cfg_b();
    do begin tick(); n++; end while (!fs_o);
    chk(n == 160, "R12 current frame keeps old length", n, 160);
    n = 0;
    do begin tick(); n++; end while (!fs_o);
    chk(n == 96, "R12 next frame uses new length", n, 96);
    os = 1;
    repeat (200) tick();
    finish_run();
  end
endmodule